// File: doc/BRIEF.md
# BCD Calendar Timekeeper

This block keeps wall-clock time and a calendar in packed BCD: seconds, minutes, hours in 24-hour form, day of month, weekday, month, a two-digit year and a century flag. A prescaler counts pulses of a 32.768 kHz tick enable and produces one advance of the seconds field per full prescaler period. The counting chain then carries through minutes and hours, through days (which follow month length and leap years), and through months and years.

A host reaches the fields through a byte-wide register port. It drives an address, a write strobe and write data, and it sees the addressed byte on a combinational read port. To load a new time, the host sets the freeze bit in the control register, writes the seven time bytes and then clears the freeze bit. While frozen, nothing advances and the prescaler stays cleared, so the first second after release lasts a full period. A supply-low flag in the top bit of the seconds byte marks the time as untrusted. Reset sets this flag, and only a host write changes it.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the fields read seconds 0x80 (flag set, 00 s), minutes 0x00, hours 0x00, day 0x01, weekday 0x00, month 0x01, year 0x00, and the control byte reads 0x00.
- R2: Register addresses are 0x00 control, 0x01 auxiliary, 0x02 seconds, 0x03 minutes, 0x04 hours, 0x05 day, 0x06 weekday, 0x07 month, 0x08 year. Field bits above each width read as zero: seconds and minutes use bits 6:0, hours and day use bits 5:0, weekday uses bits 2:0, month uses bits 4:0 and year uses 7:0. Address 0x01 and addresses above 0x08 ignore writes and read 0x00.
- R3: While running, seconds advance by one after every PRESC_DIV tick pulses and step 59 to 00, carrying into minutes.
- R4: Minutes step 59 to 00 and carry into hours. Hours step 23 to 00 and carry into day and weekday.
- R5: Weekday advances with each day carry and steps 6 to 0.
- R6: Day steps to 01 with a carry into month after day 31 in months 1, 3, 5, 7, 8, 10 and 12, and after day 30 in months 4, 6, 9 and 11.
- R7: In month 2 the last day is 29 when the year value is divisible by 4 (00 included) and 28 otherwise.
- R8: Month steps 12 to 01 and advances the year. The year steps 99 to 00 and inverts the century flag, which is bit 7 of the month byte.
- R9: Control bit 5 is the freeze bit and is the only control bit kept. While it is set no field advances and the prescaler is held at zero, so after release the first second needs a full PRESC_DIV tick pulses.
- R10: The supply-low flag is bit 7 of the seconds byte. Counting never changes it, and a write to seconds sets it to the written bit 7.
- R11: A host write loads the masked byte into the addressed field, and the century flag into month bit 7. A write takes priority over a count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz rate |
| reg_addr | input | AW | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |

## Verification
The bench aims at the cascade corners. These are a full wrap from 23:59:59 on 31 December of year 99, which must clear every field and invert the century flag. They also include the last days of 30-day and 31-day months, and February in leap and common years, including year 00. A wrong month-length table shows up as a day 31 in April or a missing 29 February. The bench also checks prescaler release: a block that kept a partial count across a freeze would advance early, and one that counted while frozen would change seconds during the load. The flag checks catch a supply-low bit cleared by counting or lost on a write. Random calendar points near midnight, checked against a bench model, cover the rest.

// File: rtl/rtcal_pkg.sv
package rtcal_pkg;

  localparam int ADR_CTRL  = 0;
  localparam int ADR_AUX   = 1;
  localparam int ADR_SEC   = 2;
  localparam int ADR_MIN   = 3;
  localparam int ADR_HOUR  = 4;
  localparam int ADR_DAY   = 5;
  localparam int ADR_WDAY  = 6;
  localparam int ADR_MONTH = 7;
  localparam int ADR_YEAR  = 8;

  localparam int FREEZE_BIT = 5;

  // next packed BCD value (no upper bound)
  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // year held in BCD is divisible by 4
  function automatic logic bcd_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else       return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  // last day of the month, BCD
  function automatic logic [5:0] last_day(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      return bcd_leap(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtcal_prescaler.sv
module rtcal_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  output logic sec_pulse
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign sec_pulse = run && tick && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)          cnt_d = '0;
    else if (tick)     cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_PRESC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R9
  AST_PRESC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/rtcal_bcd_field.sv
module rtcal_bcd_field #(
  parameter int W       = 7,
  parameter int MIN_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] max_val,
  output logic [W-1:0] val,
  output logic         carry
);
  import rtcal_pkg::*;

  localparam logic [W-1:0] FLOOR = W'(MIN_VAL);

  logic [W-1:0] val_q, val_d;
  logic [7:0]   ext_cur, ext_nxt;

  assign ext_cur = 8'(val_q);
  assign ext_nxt = bcd_next(ext_cur);
  assign carry   = inc && (val_q >= max_val);
  assign val     = val_q;

  always_comb begin
    val_d = val_q;
    if (ld)          val_d = ld_val;
    else if (carry)  val_d = FLOOR;
    else if (inc)    val_d = ext_nxt[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= FLOOR;
    else        val_q <= val_d;
  end

  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !ld) |=> $stable(val_q)); // R9
  AST_FIELD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (carry && !ld) |=> (val_q == FLOOR)); // R3
  AST_FIELD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (val_q == $past(ld_val))); // R11

endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper #(
  parameter int PRESC_DIV = 32768,
  parameter int AW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_32k,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata
);
  import rtcal_pkg::*;

  logic wr_ctrl, wr_sec, wr_min, wr_hour, wr_day, wr_wday, wr_month, wr_year;
  assign wr_ctrl  = reg_wr && (reg_addr == AW'(ADR_CTRL));
  assign wr_sec   = reg_wr && (reg_addr == AW'(ADR_SEC));
  assign wr_min   = reg_wr && (reg_addr == AW'(ADR_MIN));
  assign wr_hour  = reg_wr && (reg_addr == AW'(ADR_HOUR));
  assign wr_day   = reg_wr && (reg_addr == AW'(ADR_DAY));
  assign wr_wday  = reg_wr && (reg_addr == AW'(ADR_WDAY));
  assign wr_month = reg_wr && (reg_addr == AW'(ADR_MONTH));
  assign wr_year  = reg_wr && (reg_addr == AW'(ADR_YEAR));

  // control and flag state
  logic freeze_q, freeze_d;
  logic vlow_q, vlow_d;
  logic cent_q, cent_d;

  logic sec_pulse;
  logic [6:0] sec_v, min_v;
  logic [5:0] hour_v, day_v, day_max;
  logic [2:0] wday_v;
  logic [4:0] mon_v;
  logic [7:0] year_v;
  logic c_sec, c_min, c_hour, c_day, c_wday, c_mon, c_year;

  rtcal_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick(tick_32k), .run(!freeze_q), .sec_pulse(sec_pulse));

  rtcal_bcd_field #(.W(7), .MIN_VAL(0)) u_sec (
    .clk(clk), .rst_n(rst_n), .inc(sec_pulse), .ld(wr_sec), .ld_val(reg_wdata[6:0]),
    .max_val(7'h59), .val(sec_v), .carry(c_sec));

  rtcal_bcd_field #(.W(7), .MIN_VAL(0)) u_min (
    .clk(clk), .rst_n(rst_n), .inc(c_sec), .ld(wr_min), .ld_val(reg_wdata[6:0]),
    .max_val(7'h59), .val(min_v), .carry(c_min));

  rtcal_bcd_field #(.W(6), .MIN_VAL(0)) u_hour (
    .clk(clk), .rst_n(rst_n), .inc(c_min), .ld(wr_hour), .ld_val(reg_wdata[5:0]),
    .max_val(6'h23), .val(hour_v), .carry(c_hour));

  assign day_max = last_day(mon_v, year_v);

  rtcal_bcd_field #(.W(6), .MIN_VAL(1)) u_day (
    .clk(clk), .rst_n(rst_n), .inc(c_hour), .ld(wr_day), .ld_val(reg_wdata[5:0]),
    .max_val(day_max), .val(day_v), .carry(c_day));

  rtcal_bcd_field #(.W(3), .MIN_VAL(0)) u_wday (
    .clk(clk), .rst_n(rst_n), .inc(c_hour), .ld(wr_wday), .ld_val(reg_wdata[2:0]),
    .max_val(3'd6), .val(wday_v), .carry(c_wday));

  rtcal_bcd_field #(.W(5), .MIN_VAL(1)) u_mon (
    .clk(clk), .rst_n(rst_n), .inc(c_day), .ld(wr_month), .ld_val(reg_wdata[4:0]),
    .max_val(5'h12), .val(mon_v), .carry(c_mon));

  rtcal_bcd_field #(.W(8), .MIN_VAL(0)) u_year (
    .clk(clk), .rst_n(rst_n), .inc(c_mon), .ld(wr_year), .ld_val(reg_wdata),
    .max_val(8'h99), .val(year_v), .carry(c_year));

  always_comb begin
    freeze_d = wr_ctrl  ? reg_wdata[FREEZE_BIT] : freeze_q;
    vlow_d   = wr_sec   ? reg_wdata[7] : vlow_q;
    cent_d   = cent_q;
    if (wr_month)    cent_d = reg_wdata[7];
    else if (c_year) cent_d = ~cent_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeze_q <= 1'b0;
      vlow_q   <= 1'b1;
      cent_q   <= 1'b0;
    end else begin
      freeze_q <= freeze_d;
      vlow_q   <= vlow_d;
      cent_q   <= cent_d;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      AW'(ADR_CTRL):  reg_rdata[FREEZE_BIT] = freeze_q;
      AW'(ADR_SEC):   reg_rdata = {vlow_q, sec_v};
      AW'(ADR_MIN):   reg_rdata = {1'b0, min_v};
      AW'(ADR_HOUR):  reg_rdata = {2'b00, hour_v};
      AW'(ADR_DAY):   reg_rdata = {2'b00, day_v};
      AW'(ADR_WDAY):  reg_rdata = {5'b00000, wday_v};
      AW'(ADR_MONTH): reg_rdata = {cent_q, 2'b00, mon_v};
      AW'(ADR_YEAR):  reg_rdata = year_v;
      default:        reg_rdata = 8'h00;
    endcase
  end

  AST_FREEZE_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_q && !reg_wr) |=> $stable(sec_v)); // R9
  AST_FREEZE_DAY: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_q && !reg_wr) |=> $stable(day_v)); // R9
  AST_VLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (vlow_q && !wr_sec) |=> vlow_q); // R10
  AST_CENTURY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (c_year && !wr_month) |=> (cent_q != $past(cent_q))); // R8
  AST_MONTH_TO_YEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (c_mon && !wr_year) |=> (year_v != $past(year_v))); // R8
  AST_DAY_TO_WDAY: assert property (@(posedge clk) disable iff (!rst_n)
    (c_hour && !wr_wday && !wr_day) |=> (wday_v != $past(wday_v))); // R5

endmodule

// File: tb/bcd_timekeeper_test.sv
`timescale 1ns/1ps
module bcd_timekeeper_test;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [3:0] addr = 4'd0;
  logic wr = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // model state
  int m_s, m_mi, m_h, m_d, m_wd, m_mo, m_y, m_cen, m_vl, m_frz;

  always #2.5 clk = ~clk;

  bcd_timekeeper #(.PRESC_DIV(DIV), .AW(4)) uut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick), .reg_addr(addr),
    .reg_wr(wr), .reg_wdata(wdata), .reg_rdata(rdata));

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mlen(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_reg(input int a);
    case (a)
      0: return m_frz ? 8'h20 : 8'h00;
      2: return bcd(m_s) | (m_vl ? 8'h80 : 8'h00);
      3: return bcd(m_mi);
      4: return bcd(m_h);
      5: return bcd(m_d);
      6: return bcd(m_wd);
      7: return bcd(m_mo) | (m_cen ? 8'h80 : 8'h00);
      8: return bcd(m_y);
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_second();
    m_s++;
    if (m_s < 60) return;
    m_s = 0; m_mi++;
    if (m_mi < 60) return;
    m_mi = 0; m_h++;
    if (m_h < 24) return;
    m_h = 0; m_wd = (m_wd + 1) % 7; m_d++;
    if (m_d <= mlen(m_mo, m_y)) return;
    m_d = 1; m_mo++;
    if (m_mo <= 12) return;
    m_mo = 1; m_y++;
    if (m_y > 99) begin m_y = 0; m_cen = 1 - m_cen; end
  endtask

  task automatic check(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic wr_reg(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = 4'(a); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = 4'(a);
    #1;
    d = rdata;
  endtask

  task automatic check_reg(input string req, input int a);
    logic [7:0] v;
    rd_reg(a, v);
    check(req, $sformatf("addr %0d", a), v, exp_reg(a));
  endtask

  task automatic check_all(input string req);
    for (int a = 2; a <= 8; a++) check_reg(req, a);
  endtask

  task automatic run_ticks(input int n);
    if (n <= 0) return;
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic run_secs(input int n);
    run_ticks(n * DIV);
    for (int i = 0; i < n; i++) model_second();
  endtask

  task automatic set_time(input int s, input int mi, input int h, input int d,
                          input int wd, input int mo, input int y, input int cen);
    wr_reg(0, 8'h20);
    wr_reg(2, bcd(s));
    wr_reg(3, bcd(mi));
    wr_reg(4, bcd(h));
    wr_reg(5, bcd(d));
    wr_reg(6, bcd(wd));
    wr_reg(7, bcd(mo) | (cen ? 8'h80 : 8'h00));
    wr_reg(8, bcd(y));
    wr_reg(0, 8'h00);
    m_s = s; m_mi = mi; m_h = h; m_d = d; m_wd = wd; m_mo = mo; m_y = y;
    m_cen = cen; m_vl = 0; m_frz = 0;
  endtask

  initial begin
    #900us;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    m_s = 0; m_mi = 0; m_h = 0; m_d = 1; m_wd = 0; m_mo = 1; m_y = 0;
    m_cen = 0; m_vl = 1; m_frz = 0;
    for (int a = 0; a <= 8; a++) check_reg("R1", a);

    // R10 counting keeps the flag
    run_secs(3);
    check_reg("R10", 2);

    // R2 auxiliary and out-of-range addresses
    wr_reg(1, 8'hFF);
    rd_reg(1, v); check("R2", "aux", v, 8'h00);
    wr_reg(12, 8'hFF);
    rd_reg(12, v); check("R2", "addr 12", v, 8'h00);
    check_all("R2");
    wr_reg(0, 8'hFF);
    rd_reg(0, v); check("R2", "ctrl masked", v, 8'h20);
    wr_reg(0, 8'h00);

    // R2 field masks on write
    wr_reg(0, 8'h20); m_frz = 1;
    wr_reg(3, 8'hC5); m_mi = 45;
    wr_reg(4, 8'hD2); m_h = 12;
    wr_reg(6, 8'hFD); m_wd = 5;
    check_reg("R2", 3); check_reg("R2", 4); check_reg("R2", 6);
    wr_reg(0, 8'h00); m_frz = 0;

    // R3 R4 R5 R8 full wrap
    set_time(59, 59, 23, 31, 6, 12, 99, 0);
    check_all("R11");
    run_secs(1);
    check_all("R8");
    check_reg("R5", 6);

    // R6 month ends
    set_time(59, 59, 23, 30, 2, 4, 21, 0); run_secs(1); check_all("R6");
    set_time(59, 59, 23, 30, 2, 1, 21, 0); run_secs(1); check_all("R6");
    set_time(59, 59, 23, 31, 2, 1, 21, 0); run_secs(1); check_all("R6");
    set_time(59, 59, 23, 30, 3, 11, 21, 1); run_secs(1); check_all("R6");

    // R7 February
    set_time(59, 59, 23, 28, 0, 2, 24, 0); run_secs(1); check_all("R7");
    run_secs(24 * 3600 > 0 ? 0 : 0);
    set_time(59, 59, 23, 29, 0, 2, 24, 0); run_secs(1); check_all("R7");
    set_time(59, 59, 23, 28, 0, 2, 23, 0); run_secs(1); check_all("R7");
    set_time(59, 59, 23, 28, 0, 2, 0, 1);  run_secs(1); check_all("R7");
    set_time(59, 59, 23, 28, 0, 2, 90, 0); run_secs(1); check_all("R7");

    // R3 R4 minute and hour carries
    set_time(58, 59, 9, 15, 3, 6, 50, 0); run_secs(3); check_all("R4");
    set_time(55, 12, 3, 15, 3, 6, 50, 0); run_secs(7); check_all("R3");

    // R9 freeze holds time and prescaler
    set_time(10, 20, 5, 5, 1, 5, 30, 0);
    wr_reg(0, 8'h20); m_frz = 1;
    run_ticks(5 * DIV);
    check_all("R9");
    check_reg("R9", 0);
    wr_reg(0, 8'h00); m_frz = 0;
    run_ticks(DIV - 1);
    check_reg("R9", 2);
    run_ticks(1); model_second();
    check_reg("R9", 2);
    run_ticks(2);
    wr_reg(0, 8'h20);
    wr_reg(0, 8'h00);
    run_ticks(DIV - 1);
    check_reg("R9", 2);
    run_ticks(1); model_second();
    check_reg("R9", 2);

    // R10 flag written both ways
    wr_reg(2, 8'h85); m_s = 5; m_vl = 1;
    check_reg("R10", 2);
    run_secs(2);
    check_reg("R10", 2);
    wr_reg(2, 8'h33); m_s = 33; m_vl = 0;
    check_reg("R10", 2);

    // R11 century written directly
    wr_reg(7, 8'h81); m_mo = 1; m_cen = 1;
    check_reg("R11", 7);
    wr_reg(7, 8'h09); m_mo = 9; m_cen = 0;
    check_reg("R11", 7);

    // random calendar points, often near midnight
    for (int it = 0; it < 24; it++) begin
      int mo, y, d, s, mi, h, n;
      mo = 1 + int'($urandom_range(11));
      y  = int'($urandom_range(99));
      d  = 1 + int'($urandom_range(mlen(mo, y) - 1));
      if ($urandom_range(1) == 1) begin
        h = 23; mi = 59; s = 30 + int'($urandom_range(29));
        if ($urandom_range(1) == 1) d = mlen(mo, y);
        if ($urandom_range(3) == 0) begin mo = 12; d = 31; end
      end else begin
        h = int'($urandom_range(23)); mi = int'($urandom_range(59)); s = int'($urandom_range(59));
      end
      n = 1 + int'($urandom_range(90));
      set_time(s, mi, h, d, int'($urandom_range(6)), mo, y, int'($urandom_range(1)));
      run_secs(n);
      check_all("R6");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule